// File: doc/BRIEF.md
# Shared-Bus Management Address Bridge

This block sits behind the management-bus front end of a device that may share its management bus with other devices. The front end hands it one decoded frame per request: a 5-bit bus address, a 5-bit register number, a read/write flag and 16 bits of write data. The block answers with read data one cycle later, or with a not-responding flag when the frame is not meant for it. Behind it sits a store of 32 sub-devices of 32 sixteen-bit registers each. A local read port lets the rest of the chip inspect any stored register.

Two strap inputs fix how the block appears on the bus. They are `strap_addr`, which holds address bits 4..1 (address bit 0 is always zero), and `half_sel`. When `half_sel` is high, the block claims half of the address space. Only the top strap bit is used, and bus address base+n reaches sub-device n. When `half_sel` is low and the strap is zero, the block claims the whole bus, and address n reaches sub-device n. Any other strap value puts the block in windowed mode. It then answers only at its even strapped address, and it exposes there a command register and a data register. These two registers reach the store indirectly through a busy-flagged command.

Top module: `mgmt_addr_bridge`

## Requirements
- R1: With `half_sel`=0 and `strap_addr`=0 (flat mode), every bus address answers. A write to address a, register r stores into sub-device a, register r. The write is visible on the local port (`loc_dev`, `loc_reg`, `loc_rdata`) from the next cycle on.
- R2: A read request gets `rsp_valid`=1 on the cycle after the request. In flat mode `rsp_data` holds the stored value. A write request produces no `rsp_valid`. After reset, `rsp_valid` is 0.
- R3: With `half_sel`=0 and `strap_addr`=s≠0 (windowed mode), only bus address {s,0} answers. A read at any other address returns `rsp_nack`=1 with `rsp_data`=0, and a write there changes nothing.
- R4: In windowed mode, register 0 at the strapped address is the command register and register 1 is the data register. Both reset to 0. Other register numbers read as 0 without nack, and writes to them are ignored.
- R5: The command word has busy at bit 15, the opcode at bits 12:11, the sub-device at bits 9:5 and the register at bits 4:0. A command written with bit 15 set while idle reads back with bit 15 set for exactly 4 cycles, counted from the cycle after the write, and then with bit 15 clear. A command written with bit 15 clear is stored and starts nothing.
- R6: Opcode 01 (write) copies the data register into the addressed sub-device register when busy clears.
- R7: Opcode 10 (read) loads the data register with the addressed sub-device register when busy clears.
- R8: Opcodes 00 and 11 clear busy after the same 4 cycles. They change neither the store nor the data register.
- R9: While busy is set, bus writes to the command or data register are ignored.
- R10: With `half_sel`=1, the block answers exactly the 16 addresses whose bit 4 equals `strap_addr[3]`. Bus address base+n maps to sub-device n, and other addresses nack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 4 | Strapped bus address bits 4..1 |
| half_sel | input | 1 | Selects the half-range mapping |
| bus_req | input | 1 | One-cycle strobe of a decoded bus frame |
| bus_wr | input | 1 | 1 = write frame, 0 = read frame |
| bus_phy | input | 5 | Bus (device) address of the frame |
| bus_reg | input | 5 | Register number of the frame |
| bus_wdata | input | 16 | Write data of the frame |
| rsp_valid | output | 1 | Read response present |
| rsp_nack | output | 1 | Read frame not answered by this block |
| rsp_data | output | 16 | Read response data |
| loc_dev | input | 5 | Local read port sub-device |
| loc_reg | input | 5 | Local read port register |
| loc_rdata | output | 16 | Local read port data (combinational) |

## Verification
A read response is registered, so it is due one cycle after the request. The bench raises each request just after a falling edge and samples the response at the next falling edge. An indirect command is accepted at edge k and keeps busy visible through edge k+4. The bench reads the command register at k+1 and at k+4 and expects busy set, then reads at k+5 and expects it clear, which pins the 4-cycle latency to the exact cycle. Store updates from writes, direct or indirect, are read on the local port one falling edge after the edge that performs them.

// File: rtl/mab_pkg.sv
// Package: shared widths, mode type and command-word field positions
// for the management address bridge. Assumes 5-bit bus addresses.
package mab_pkg;
    localparam int ADDR_W = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        AM_FLAT   = 2'd0,
        AM_WINDOW = 2'd1,
        AM_HALF   = 2'd2
    } amode_t;

    // Command word layout
    localparam int CMD_BUSY   = 15;
    localparam int CMD_OP_HI  = 12;
    localparam int CMD_OP_LO  = 11;
    localparam int CMD_DEV_HI = 9;
    localparam int CMD_DEV_LO = 5;
    localparam int CMD_REG_HI = 4;
    localparam int CMD_REG_LO = 0;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
endpackage

// File: rtl/mab_decode.sv
// Address decoder: turns the strap pins and a frame's bus address into the
// addressing mode, a hit flag and the target sub-device number.
// Assumes the straps are stable outside reset.
module mab_decode
    import mab_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-2:0] strap,
    input  logic          half,
    input  logic [AW-1:0] phy,
    output amode_t        mode,
    output logic          hit,
    output logic [AW-1:0] dev
);
    // Mode pick and address match; half-range has priority over the strap value
    always_comb begin
        if (half) begin
            mode = AM_HALF;
            hit  = (phy[AW-1] == strap[AW-2]);
            dev  = {1'b0, phy[AW-2:0]};
        end else if (strap == '0) begin
            mode = AM_FLAT;
            hit  = 1'b1;
            dev  = phy;
        end else begin
            mode = AM_WINDOW;
            hit  = (phy == {strap, 1'b0});
            dev  = '0;
        end
    end
endmodule

// File: rtl/mab_regfile.sv
// Sub-device register store: NDEV x NREG words, one synchronous write port,
// NRD combinational read ports. Contents are not cleared by reset.
module mab_regfile #(
    parameter int DEV_W = 5,
    parameter int RW    = 5,
    parameter int DW    = 16,
    parameter int NRD   = 3
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [DEV_W-1:0]          wdev,
    input  logic [RW-1:0]             wreg,
    input  logic [DW-1:0]             wdata,
    input  logic [NRD-1:0][DEV_W-1:0] rdev,
    input  logic [NRD-1:0][RW-1:0]    rreg,
    output logic [NRD-1:0][DW-1:0]    rdata
);
    localparam int DEPTH = 1 << (DEV_W + RW);

    logic [DW-1:0] mem [DEPTH];

    // Store one word per cycle
    always_ff @(posedge clk) begin
        if (we) mem[{wdev, wreg}] <= wdata;
    end

    // One asynchronous read port per requester
    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = mem[{rdev[i], rreg[i]}];
    end
endmodule

// File: rtl/mab_window.sv
// Indirect window engine: holds the command and data registers of windowed
// mode and runs one busy-flagged access LAT cycles long against the store.
// Assumes LAT >= 1.
module mab_window
    import mab_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              busy,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_dev,
    output logic [REG_W-1:0]  rf_reg,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt;
    logic [1:0]       opc;
    logic             done;

    // Field extraction and completion strobe
    assign busy     = cmd_q[CMD_BUSY];
    assign opc      = cmd_q[CMD_OP_HI:CMD_OP_LO];
    assign rf_dev   = cmd_q[CMD_DEV_HI:CMD_DEV_LO];
    assign rf_reg   = cmd_q[CMD_REG_HI:CMD_REG_LO];
    assign done     = busy && (cnt == '0);
    assign rf_we    = done && (opc == OPC_WRITE);
    assign rf_wdata = data_q;

    // Command/data registers and latency counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
            cnt    <= '0;
        end else if (busy) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                cmd_q[CMD_BUSY] <= 1'b0;
                if (opc == OPC_READ) data_q <= rf_rdata;
            end
        end else if (en && wr_en) begin
            if (wr_off == REG_W'(0)) begin
                cmd_q <= wr_data;
                cnt   <= CNT_W'(LAT - 1);
            end else if (wr_off == REG_W'(1)) begin
                data_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/mgmt_addr_bridge.sv
// Top: management address bridge. Decodes each bus frame against the
// straps, serves flat/half-range frames straight from the store and
// windowed frames through the command/data engine. Read responses are
// registered (one cycle). Assumes at most one frame per cycle.
module mgmt_addr_bridge
    import mab_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        strap_addr,
    input  logic              half_sel,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [4:0]        bus_phy,
    input  logic [4:0]        bus_reg,
    input  logic [15:0]       bus_wdata,
    output logic              rsp_valid,
    output logic              rsp_nack,
    output logic [15:0]       rsp_data,
    input  logic [4:0]        loc_dev,
    input  logic [4:0]        loc_reg,
    output logic [15:0]       loc_rdata
);
    localparam int NRD = 3;

    amode_t                     mode;
    logic                       hit;
    logic [ADDR_W-1:0]          dec_dev;
    logic                       is_window;
    logic                       win_we;
    logic [DATA_W-1:0]          cmd_w, data_w;
    logic                       busy_w;
    logic                       eng_we;
    logic [ADDR_W-1:0]          eng_dev;
    logic [REG_W-1:0]           eng_reg;
    logic [DATA_W-1:0]          eng_wdata;
    logic                       rf_we;
    logic [ADDR_W-1:0]          rf_wdev;
    logic [REG_W-1:0]           rf_wreg;
    logic [DATA_W-1:0]          rf_wdata;
    logic [NRD-1:0][ADDR_W-1:0] rd_dev;
    logic [NRD-1:0][REG_W-1:0]  rd_reg;
    logic [NRD-1:0][DATA_W-1:0] rd_data;
    logic                       rd_req;
    logic [DATA_W-1:0]          rd_sel;

    mab_decode u_dec (
        .strap (strap_addr),
        .half  (half_sel),
        .phy   (bus_phy),
        .mode  (mode),
        .hit   (hit),
        .dev   (dec_dev)
    );

    assign is_window = (mode == AM_WINDOW);
    assign win_we    = bus_req && bus_wr && hit && is_window;
    assign rd_req    = bus_req && !bus_wr;

    mab_window #(.LAT(LAT)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (is_window),
        .wr_en    (win_we),
        .wr_off   (bus_reg),
        .wr_data  (bus_wdata),
        .cmd_q    (cmd_w),
        .data_q   (data_w),
        .busy     (busy_w),
        .rf_we    (eng_we),
        .rf_dev   (eng_dev),
        .rf_reg   (eng_reg),
        .rf_wdata (eng_wdata),
        .rf_rdata (rd_data[1])
    );

    // Store write-port steering: engine in windowed mode, bus otherwise
    always_comb begin
        if (is_window) begin
            rf_we    = eng_we;
            rf_wdev  = eng_dev;
            rf_wreg  = eng_reg;
            rf_wdata = eng_wdata;
        end else begin
            rf_we    = bus_req && bus_wr && hit;
            rf_wdev  = dec_dev;
            rf_wreg  = bus_reg;
            rf_wdata = bus_wdata;
        end
    end

    // Read ports: 0 = bus direct, 1 = engine, 2 = local
    assign rd_dev[0] = dec_dev;
    assign rd_reg[0] = bus_reg;
    assign rd_dev[1] = eng_dev;
    assign rd_reg[1] = eng_reg;
    assign rd_dev[2] = loc_dev;
    assign rd_reg[2] = loc_reg;
    assign loc_rdata = rd_data[2];

    mab_regfile #(.DEV_W(ADDR_W), .RW(REG_W), .DW(DATA_W), .NRD(NRD)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .wdev  (rf_wdev),
        .wreg  (rf_wreg),
        .wdata (rf_wdata),
        .rdev  (rd_dev),
        .rreg  (rd_reg),
        .rdata (rd_data)
    );

    // Read-data selection for an answered frame
    always_comb begin
        if (is_window) begin
            if (bus_reg == REG_W'(0))      rd_sel = cmd_w;
            else if (bus_reg == REG_W'(1)) rd_sel = data_w;
            else                           rd_sel = '0;
        end else begin
            rd_sel = rd_data[0];
        end
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_nack  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_nack  <= rd_req && !hit;
            rsp_data  <= (rd_req && hit) ? rd_sel : '0;
        end
    end
endmodule

// File: rtl/mab_checker.sv
// Checker for mgmt_addr_bridge: response protocol, busy length, command
// lock while busy and write-port ownership. Attached with bind below.
module mab_checker #(
    parameter int LAT = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_wr,
    input logic        rsp_valid,
    input logic        rsp_nack,
    input logic [15:0] rsp_data,
    input logic        busy,
    input logic        win_we,
    input logic [15:0] cmd_q,
    input logic        rf_we,
    input logic        window_mode
);
    logic [7:0] bcnt;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                bcnt <= '0;
        else if (!busy)            bcnt <= '0;
        else if (bcnt != 8'hFF)    bcnt <= bcnt + 1'b1;
    end

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == 8'(LAT)));

    p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr) |=> rsp_valid);

    p_no_rsp_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr) |=> !rsp_valid);

    p_nack_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nack |-> (rsp_valid && rsp_data == 16'h0000));

    p_cmd_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && win_we) |=> $stable(cmd_q[14:0]));

    p_flat_never_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !window_mode |-> !busy);

    p_store_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (window_mode && rf_we) |-> busy);
endmodule

bind mgmt_addr_bridge mab_checker #(.LAT(LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .rsp_valid   (rsp_valid),
    .rsp_nack    (rsp_nack),
    .rsp_data    (rsp_data),
    .busy        (busy_w),
    .win_we      (win_we),
    .cmd_q       (cmd_w),
    .rf_we       (rf_we),
    .window_mode (is_window)
);

// File: tb/mgmt_addr_bridge_tb.sv
`timescale 1ns/1ps
module mgmt_addr_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_addr = 4'd0;
    logic        half_sel = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_phy = '0;
    logic [4:0]  bus_reg = '0;
    logic [15:0] bus_wdata = '0;
    logic        rsp_valid, rsp_nack;
    logic [15:0] rsp_data;
    logic [4:0]  loc_dev = '0;
    logic [4:0]  loc_reg = '0;
    logic [15:0] loc_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mgmt_addr_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .half_sel(half_sel),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_phy(bus_phy), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .rsp_data(rsp_data), .loc_dev(loc_dev), .loc_reg(loc_reg),
        .loc_rdata(loc_rdata)
    );

    // {phy, reg, data} vectors for flat mode
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {5'd0,  5'd0,  16'h1234},
        {5'd31, 5'd31, 16'hFFFF},
        {5'd5,  5'd17, 16'hA5C3},
        {5'd6,  5'd0,  16'h0F0F},
        {5'd16, 5'd1,  16'h8001},
        {5'd9,  5'd30, 16'h0000}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] s, input logic h);
        @(negedge clk);
        rst_n = 1'b0; strap_addr = s; half_sel = h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bwr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        bus_req = 1'b1; bus_wr = 1'b1; bus_phy = p; bus_reg = r; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [4:0] p, input logic [4:0] r,
                       output logic [15:0] d, output logic nk, output logic v);
        bus_req = 1'b1; bus_wr = 1'b0; bus_phy = p; bus_reg = r;
        @(negedge clk);
        d = rsp_data; nk = rsp_nack; v = rsp_valid;
        bus_req = 1'b0;
    endtask

    task automatic loc(input logic [4:0] dv, input logic [4:0] r, output logic [15:0] d);
        loc_dev = dv; loc_reg = r;
        #0.1;
        d = loc_rdata;
    endtask

    initial begin
        logic [15:0] d;
        logic nk, v;

        // Flat mode
        do_reset(4'd0, 1'b0);
        check("R2 reset rsp_valid", {15'd0, rsp_valid}, 16'd0);
        for (int i = 0; i < NV; i++) bwr(VEC[i][25:21], VEC[i][20:16], VEC[i][15:0]);
        check("R2 no response to write", {15'd0, rsp_valid}, 16'd0);
        for (int i = 0; i < NV; i++) begin
            brd(VEC[i][25:21], VEC[i][20:16], d, nk, v);
            check("R2 read valid", {15'd0, v}, 16'd1);
            check("R1 flat read data", d, VEC[i][15:0]);
            check("R1 flat ack", {15'd0, nk}, 16'd0);
        end
        loc(5'd31, 5'd31, d); check("R1 local port", d, 16'hFFFF);
        loc(5'd5, 5'd17, d);  check("R1 local port", d, 16'hA5C3);

        // Windowed mode at address 6
        do_reset(4'b0011, 1'b0);
        brd(5'd6, 5'd0, d, nk, v); check("R4 cmd reset", d, 16'h0000);
        brd(5'd6, 5'd1, d, nk, v); check("R4 data reset", d, 16'h0000);
        brd(5'd0, 5'd0, d, nk, v);
        check("R3 foreign nack", {15'd0, nk}, 16'd1);
        check("R3 foreign data", d, 16'h0000);
        check("R3 foreign valid", {15'd0, v}, 16'd1);
        bwr(5'd0, 5'd0, 16'hDEAD);
        loc(5'd0, 5'd0, d); check("R3 foreign write ignored", d, 16'h1234);
        brd(5'd6, 5'd5, d, nk, v);
        check("R4 other offset data", d, 16'h0000);
        check("R4 other offset ack", {15'd0, nk}, 16'd0);
        bwr(5'd6, 5'd7, 16'hFFFF);
        brd(5'd6, 5'd0, d, nk, v); check("R4 other offset write ignored", d, 16'h0000);

        // Indirect write: dev 3 reg 9
        bwr(5'd6, 5'd1, 16'hBEEF);
        bwr(5'd6, 5'd0, 16'h8869);                      // edge k
        brd(5'd6, 5'd0, d, nk, v); check("R5 busy at k+1", d, 16'h8869);
        repeat (2) @(negedge clk);
        brd(5'd6, 5'd0, d, nk, v); check("R5 busy at k+4", d, 16'h8869);
        brd(5'd6, 5'd0, d, nk, v); check("R5 idle at k+5", d, 16'h0869);
        loc(5'd3, 5'd9, d); check("R6 indirect write stored", d, 16'hBEEF);

        // Indirect read: dev 5 reg 17
        bwr(5'd6, 5'd0, 16'h90B1);
        repeat (4) @(negedge clk);
        brd(5'd6, 5'd1, d, nk, v); check("R7 indirect read data", d, 16'hA5C3);
        brd(5'd6, 5'd0, d, nk, v); check("R7 busy clear", d, 16'h10B1);

        // Writes while busy: dev 7 reg 2
        bwr(5'd6, 5'd1, 16'h1111);
        bwr(5'd6, 5'd0, 16'h88E2);                      // edge k
        bwr(5'd6, 5'd1, 16'h2222);                      // k+1, ignored
        bwr(5'd6, 5'd0, 16'h9000);                      // k+2, ignored
        @(negedge clk);                                 // k+3
        brd(5'd6, 5'd0, d, nk, v); check("R9 cmd kept while busy", d, 16'h88E2);
        brd(5'd6, 5'd0, d, nk, v); check("R9 cmd idle after", d, 16'h08E2);
        brd(5'd6, 5'd1, d, nk, v); check("R9 data kept while busy", d, 16'h1111);
        loc(5'd7, 5'd2, d); check("R9 store got first data", d, 16'h1111);

        // Undefined opcode 11
        bwr(5'd6, 5'd1, 16'h3333);
        bwr(5'd6, 5'd0, 16'h98E2);
        repeat (4) @(negedge clk);
        brd(5'd6, 5'd0, d, nk, v); check("R8 busy cleared", d, 16'h18E2);
        brd(5'd6, 5'd1, d, nk, v); check("R8 data unchanged", d, 16'h3333);
        loc(5'd7, 5'd2, d); check("R8 store unchanged", d, 16'h1111);

        // Command without busy starts nothing
        bwr(5'd6, 5'd0, 16'h0869);
        brd(5'd6, 5'd0, d, nk, v); check("R5 no-busy cmd stored", d, 16'h0869);
        repeat (4) @(negedge clk);
        loc(5'd3, 5'd9, d); check("R5 no-busy cmd no write", d, 16'hBEEF);

        // Half range, upper half
        do_reset(4'b1000, 1'b1);
        bwr(5'd20, 5'd3, 16'h7777);
        loc(5'd4, 5'd3, d); check("R10 base+n to dev n", d, 16'h7777);
        brd(5'd20, 5'd3, d, nk, v); check("R10 half read", d, 16'h7777);
        brd(5'd4, 5'd3, d, nk, v); check("R10 lower half nack", {15'd0, nk}, 16'd1);

        // Half range, lower half: low strap bits are not used
        do_reset(4'b0111, 1'b1);
        brd(5'd4, 5'd3, d, nk, v); check("R10 lower read", d, 16'h7777);
        check("R10 lower ack", {15'd0, nk}, 16'd0);
        brd(5'd20, 5'd3, d, nk, v); check("R10 upper half nack", {15'd0, nk}, 16'd1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule